// File: doc/BRIEF.md
# System Clock Divider Bank

The block divides a set of system clock streams from one fast fabric clock. It works on clock-enable ticks: each source clock is presented as a one-cycle `*_tick` strobe, and each divider emits a one-cycle enable pulse once every N source ticks. A single selector chooses whether the peripheral dividers count reference ticks (bypass) or PLL ticks. The prescaler divider and the core-clock divider always count reference ticks.

There are five dividers, each with its own configuration register written through a simple write strobe. The prescaler and the core-clock divider accept any ratio from 1 to 32. The peripheral dividers accept only divide by 1, 2 or 4, and reject any other code. A ratio change is sampled only at the start of a divided period, so a period in progress always completes at its old length.

Top module: `clkdiv_bank`

## Requirements
- R1: Register write: with `wr_en` high, `wr_sel` picks the divider (0 prescaler, 1 to 3 peripheral dividers 0 to 2, 4 core-clock divider). `wr_data` bit 15 is the enable, bits 4:0 the ratio code, and bits 14:5 are ignored. After reset all outputs are low; the prescaler is enabled with code 0; the peripheral dividers are enabled with code 3; the core-clock divider is disabled with code 0.
- R2: An enabled divider with code n raises its output for exactly one cycle, one clock after every (n+1)th source tick, counting from reset or from the point it was enabled.
- R3: The prescaler (`pre_ce`) and core-clock divider (`core_ce`) divide by code+1 for every code from 0 (divide by 1) to 31 (divide by 32).
- R4: Peripheral dividers (`per_ce`) divide by 1, 2 and 4 for codes 0, 1 and 3.
- R5: A write of code 2 or of codes 4 to 31 to a peripheral divider is dropped entirely: neither its enable nor its ratio changes.
- R6: With `pll_mode` low the peripheral dividers count `ref_tick`; with it high they count `pll_tick`. The prescaler and core-clock divider count `ref_tick` in both modes.
- R7: A disabled divider holds its output low and clears its count; once re-enabled it starts a fresh period from zero.
- R8: A ratio written while a period is in progress applies from the next period; the current period ends at its old length.
- R9: A write with `wr_sel` of 5, 6 or 7 changes no divider.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle strobe per reference clock period |
| pll_tick | input | 1 | One-cycle strobe per PLL output period |
| pll_mode | input | 1 | 1: peripheral dividers count PLL ticks; 0: bypass, count reference ticks |
| wr_en | input | 1 | Configuration write strobe |
| wr_sel | input | 3 | Divider select for the write |
| wr_data | input | 16 | Write data: bit 15 enable, bits 4:0 ratio code |
| pre_ce | output | 1 | Prescaler enable pulse |
| per_ce | output | 3 | Peripheral divider enable pulses, bit k for divider k |
| core_ce | output | 1 | Core-clock divider enable pulse |

## Verification
The bench goes after the period boundaries. A ratio written mid-period must stretch or shrink only the next period. A design that loaded it at once would emit a short or long pulse gap, seen as a wrong spacing right after the write. Reserved peripheral codes are sent with the enable bit cleared: a design that checked only the ratio would stop the divider, and one that stored the code would show a period that is neither 1, 2 nor 4. The source selector is switched while reference ticks are absent or sparse, so a divider wired to the wrong source shows up as a missing pulse or a doubled spacing. Re-enable after a disable must give a full first period, which a design that kept its count would shorten.

// File: rtl/ckb_pkg.sv
package ckb_pkg;

  localparam int CKB_CODE_W = 5;
  localparam int CKB_REG_W  = 16;

  // Peripheral dividers take only the power-of-two codes 0, 1 and 3.
  function automatic logic per_code_ok(input logic [CKB_CODE_W-1:0] c);
    return (c == CKB_CODE_W'(0)) || (c == CKB_CODE_W'(1)) || (c == CKB_CODE_W'(3));
  endfunction

  // A tick ends the period when the running count reaches the limit held
  // for this period; on the first tick of a period the fresh code decides.
  function automatic logic period_end(input logic [CKB_CODE_W-1:0] cnt,
                                      input logic [CKB_CODE_W-1:0] lim,
                                      input logic [CKB_CODE_W-1:0] code);
    return (cnt == '0) ? (code == '0) : (cnt == lim);
  endfunction

endpackage

// File: rtl/ckb_cfg_reg.sv
module ckb_cfg_reg
  import ckb_pkg::*;
#(
  parameter int              CODE_W   = CKB_CODE_W,
  parameter int              REG_W    = CKB_REG_W,
  parameter bit              IS_PER   = 1'b0,
  parameter bit              RST_EN   = 1'b1,
  parameter logic [CODE_W-1:0] RST_CODE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [REG_W-1:0]  wr_data,
  output logic              en,
  output logic [CODE_W-1:0] code,
  output logic              drop
);

  logic              accept;
  logic [CODE_W-1:0] new_code;
  logic              unused_mid;

  assign new_code   = wr_data[CODE_W-1:0];
  assign unused_mid = ^wr_data[REG_W-2:CODE_W];

  generate
    if (IS_PER) begin : g_restricted
      assign accept = per_code_ok(new_code);
    end else begin : g_full
      assign accept = 1'b1;
    end
  endgenerate

  assign drop = wr && !accept;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en   <= RST_EN;
      code <= RST_CODE;
    end else if (wr && accept) begin
      en   <= wr_data[REG_W-1];
      code <= new_code;
    end
  end

endmodule

// File: rtl/ckb_counter.sv
module ckb_counter
  import ckb_pkg::*;
#(
  parameter int CODE_W = CKB_CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [CODE_W-1:0] code,
  input  logic              tick,
  output logic              wrap,
  output logic              ce_q
);

  logic [CODE_W-1:0] cnt;
  logic [CODE_W-1:0] lim;

  always_comb wrap = en && tick && period_end(cnt, lim, code);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      lim  <= '0;
      ce_q <= 1'b0;
    end else begin
      ce_q <= wrap;
      if (!en) begin
        cnt <= '0;
      end else if (tick) begin
        if (wrap) begin
          cnt <= '0;
        end else begin
          cnt <= cnt + CODE_W'(1);
          if (cnt == '0) lim <= code;  // ratio fixed for the whole period
        end
      end
    end
  end

endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
  import ckb_pkg::*;
#(
  parameter  int N_PER  = 3,
  parameter  int CODE_W = CKB_CODE_W,
  parameter  int REG_W  = CKB_REG_W,
  localparam int N_DIV  = N_PER + 2,
  localparam int SEL_W  = $clog2(N_DIV)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_tick,
  input  logic             pll_tick,
  input  logic             pll_mode,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [REG_W-1:0] wr_data,
  output logic             pre_ce,
  output logic [N_PER-1:0] per_ce,
  output logic             core_ce
);

  localparam int PER_RST_CODE = 3;

  // Named internal events, one bit per divider (0 pre, 1..N_PER peripheral,
  // N_DIV-1 core).
  logic                           src_tick;
  logic [N_DIV-1:0]               en_v;
  logic [N_DIV-1:0][CODE_W-1:0]   code_v;
  logic [N_DIV-1:0]               tick_v;
  logic [N_DIV-1:0]               wrap_v;
  logic [N_DIV-1:0]               ce_v;
  logic [N_DIV-1:0]               drop_v;

  assign src_tick = pll_mode ? pll_tick : ref_tick;

  generate
    for (genvar i = 0; i < N_DIV; i++) begin : g_div
      localparam bit IS_PER = (i >= 1) && (i <= N_PER);
      localparam bit RST_EN = (i != N_DIV - 1);
      localparam logic [CODE_W-1:0] RST_CODE = IS_PER ? CODE_W'(PER_RST_CODE) : '0;

      logic wr_this;
      assign wr_this   = wr_en && (wr_sel == SEL_W'(i));
      assign tick_v[i] = IS_PER ? src_tick : ref_tick;

      ckb_cfg_reg #(
        .CODE_W  (CODE_W),
        .REG_W   (REG_W),
        .IS_PER  (IS_PER),
        .RST_EN  (RST_EN),
        .RST_CODE(RST_CODE)
      ) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (wr_this),
        .wr_data(wr_data),
        .en     (en_v[i]),
        .code   (code_v[i]),
        .drop   (drop_v[i])
      );

      ckb_counter #(
        .CODE_W(CODE_W)
      ) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (en_v[i]),
        .code (code_v[i]),
        .tick (tick_v[i]),
        .wrap (wrap_v[i]),
        .ce_q (ce_v[i])
      );
    end
  endgenerate

  assign pre_ce  = ce_v[0];
  assign per_ce  = ce_v[N_PER:1];
  assign core_ce = ce_v[N_DIV-1];

endmodule

// File: rtl/ckb_checker.sv
module ckb_checker
  import ckb_pkg::*;
#(
  parameter  int N_PER  = 3,
  parameter  int CODE_W = CKB_CODE_W,
  localparam int N_DIV  = N_PER + 2
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [N_DIV-1:0]             en_v,
  input logic [N_DIV-1:0][CODE_W-1:0] code_v,
  input logic [N_DIV-1:0]             tick_v,
  input logic [N_DIV-1:0]             wrap_v,
  input logic [N_DIV-1:0]             ce_v,
  input logic [N_DIV-1:0]             drop_v
);

  generate
    for (genvar i = 0; i < N_DIV; i++) begin : g_chk
      // R7: a disabled divider produces no pulse on the following cycle.
      p_off_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en_v[i] |=> !ce_v[i]);

      // R2: every output pulse follows a source tick.
      p_pulse_after_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ce_v[i] |-> $past(tick_v[i]));

      // R2: a period end is always echoed as a pulse one cycle later.
      p_wrap_echo_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_v[i] |=> ce_v[i]);

      // R8: after a pulse, a non-unit code cannot end the next period at once.
      p_no_short_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_v[i] && code_v[i] != '0) |=> !ce_v[i]);

      // R5: a dropped write leaves the configuration untouched.
      p_keep_cfg_r5: assert property (@(posedge clk) disable iff (!rst_n)
        drop_v[i] |=> ($stable(code_v[i]) && $stable(en_v[i])));
    end

    for (genvar k = 1; k <= N_PER; k++) begin : g_per
      // R4: peripheral dividers only ever hold a legal code.
      p_code_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        per_code_ok(code_v[k]));
    end
  endgenerate

endmodule

bind clkdiv_bank ckb_checker #(
  .N_PER (N_PER),
  .CODE_W(CODE_W)
) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .en_v  (en_v),
  .code_v(code_v),
  .tick_v(tick_v),
  .wrap_v(wrap_v),
  .ce_v  (ce_v),
  .drop_v(drop_v)
);

// File: tb/sim_clkdiv_bank.sv
`timescale 1ns/1ps
module sim_clkdiv_bank;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ref_tick, pll_tick, pll_mode;
  logic        wr_en;
  logic [2:0]  wr_sel;
  logic [15:0] wr_data;
  logic        pre_ce, core_ce;
  logic [2:0]  per_ce;

  always #10 clk = ~clk;  // 50 MHz

  clkdiv_bank u0 (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .pll_tick(pll_tick),
    .pll_mode(pll_mode), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .pre_ce(pre_ce), .per_ce(per_ce), .core_ce(core_ce)
  );

  wire [4:0] outs = {core_ce, per_ce, pre_ce};

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  bit done    = 1'b0;

  // Tick generators: period in fabric cycles, 0 = no ticks.
  int ref_div = 1;
  int pll_div = 1;
  int phase   = 0;
  always @(negedge clk) begin
    phase++;
    ref_tick <= (ref_div != 0) && (phase % ref_div == 0);
    pll_tick <= (pll_div != 0) && (phase % pll_div == 0);
  end

  // Behavioural reference: remaining ticks per period.
  int       m_en[5];
  int       m_code[5];
  int       m_rem[5];
  logic [4:0] m_out;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int d = 0; d < 5; d++) begin
        m_en[d]   = (d == 4) ? 0 : 1;
        m_code[d] = (d >= 1 && d <= 3) ? 3 : 0;
        m_rem[d]  = 0;
      end
      m_out = '0;
    end else begin
      for (int d = 0; d < 5; d++) begin
        logic tk;
        tk = (d >= 1 && d <= 3) ? (pll_mode ? pll_tick : ref_tick) : ref_tick;
        if (m_en[d] == 0) begin
          m_rem[d] = 0;
          m_out[d] = 1'b0;
        end else if (tk) begin
          if (m_rem[d] == 0) m_rem[d] = m_code[d] + 1;
          m_rem[d] = m_rem[d] - 1;
          m_out[d] = (m_rem[d] == 0);
        end else begin
          m_out[d] = 1'b0;
        end
      end
      if (wr_en && wr_sel < 3'd5) begin
        int d;
        int c;
        d = int'(wr_sel);
        c = int'(wr_data[4:0]);
        if (!(d >= 1 && d <= 3 && !(c == 0 || c == 1 || c == 3))) begin
          m_en[d]   = int'(wr_data[15]);
          m_code[d] = c;
        end
      end
    end
  end

  // Cycle compare against the reference (R2 and every divider's function).
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      for (int d = 0; d < 5; d++) begin
        n_tests++;
        if (outs[d] !== m_out[d]) begin
          n_fail++;
          $display("FAIL R2 cycle %0d divider %0d: actual %b expected %b",
                   cyc, d, outs[d], m_out[d]);
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [15:0] data);
    wr_en   = 1'b1;
    wr_sel  = sel;
    wr_data = data;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic wait_pulse(input int idx, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!outs[idx] && n < 400);
  endtask

  task automatic measure(input int idx, input int exp, input string req,
                         input string what);
    int n;
    wait_pulse(idx, n);
    wait_pulse(idx, n);
    chk(n == exp, req, what, n, exp);
  endtask

  task automatic count_pulses(input int idx, input int cycles, output int cnt);
    cnt = 0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      if (outs[idx]) cnt++;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected under 50000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    rst_n    = 1'b0;
    pll_mode = 1'b0;
    wr_en    = 1'b0;
    wr_sel   = '0;
    wr_data  = '0;
    ref_tick = 1'b0;
    pll_tick = 1'b0;
    repeat (3) @(negedge clk);
    chk(outs == 5'b0, "R1", "outputs in reset", int'(outs), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset configuration seen at the outputs
    measure(1, 4, "R1", "peripheral reset ratio /4");
    measure(0, 1, "R1", "prescaler reset ratio /1");
    count_pulses(4, 20, n);
    chk(n == 0, "R1", "core divider off after reset", n, 0);

    // R3: full-range dividers, reserved bits set in the second write
    wr(3'd0, 16'h801F);
    measure(0, 32, "R3", "prescaler /32");
    wr(3'd4, 16'hFFE4);
    measure(4, 5, "R3", "core divider /5 with reserved bits set");
    wr(3'd4, 16'h8000);
    measure(4, 1, "R3", "core divider /1");
    wr(3'd4, 16'h8004);

    // R4: peripheral ratios
    wr(3'd1, 16'h8001);
    measure(1, 2, "R4", "peripheral 0 /2");
    wr(3'd2, 16'h8000);
    measure(2, 1, "R4", "peripheral 1 /1");
    wr(3'd3, 16'h8003);
    measure(3, 4, "R4", "peripheral 2 /4");

    // R5: reserved codes dropped, enable bit included
    wr(3'd1, 16'h8002);
    measure(1, 2, "R5", "code 2 ignored");
    wr(3'd1, 16'h0009);
    measure(1, 2, "R5", "code 9 with enable clear ignored");

    // R9: out-of-range select
    wr(3'd5, 16'h0000);
    wr(3'd7, 16'h8000);
    measure(1, 2, "R9", "peripheral 0 after select 5/7");
    measure(4, 5, "R9", "core divider after select 5/7");

    // R7: disable then re-enable
    wr(3'd2, 16'h0000);
    count_pulses(2, 40, n);
    chk(n == 0, "R7", "disabled peripheral 1 pulses", n, 0);
    wr(3'd2, 16'h8003);
    wait_pulse(2, n);
    chk(n == 4, "R7", "first period after re-enable", n, 4);

    // R8: ratio change at boundary only
    wait_pulse(3, n);
    wr(3'd3, 16'h8000);
    wait_pulse(3, n);
    chk(n == 3, "R8", "old period completes after write", n, 3);
    wait_pulse(3, n);
    chk(n == 1, "R8", "new ratio in next period", n, 1);

    // R6: source selection
    pll_mode = 1'b1;
    ref_div  = 0;
    pll_div  = 1;
    repeat (4) @(negedge clk);
    measure(1, 2, "R6", "peripheral 0 on PLL ticks");
    count_pulses(0, 30, n);
    chk(n == 0, "R6", "prescaler ignores PLL ticks", n, 0);
    ref_div = 2;
    repeat (4) @(negedge clk);
    measure(4, 10, "R6", "core divider on reference in PLL mode");
    measure(1, 2, "R6", "peripheral 0 still on PLL ticks");
    pll_mode = 1'b0;
    repeat (4) @(negedge clk);
    measure(1, 4, "R6", "peripheral 0 on reference in bypass");

    repeat (5) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule